// File: doc/BRIEF.md
# Deferred Auto-Refresh Scheduler with Three-Way Bus Arbitration

This block decides when an SDRAM auto-refresh is due and who owns the shared memory bus on each clock. Three masters compete for the bus: a display DMA engine, the refresh engine, and the CPU. Priority is fixed. The display engine wins first, then the refresh engine, and the CPU comes last. A free-running interval timer raises one refresh request every time it expires. The expiry period is chosen by a 3-bit select and is counted in system clock cycles.

A refresh request is never dropped. If the display engine keeps the bus across one or more timer expiries, each missed refresh is added to a small saturating backlog counter. The timer keeps running meanwhile. Once the display engine lets go of the bus, the stored refreshes run one after another, each taking the bus for two clocks. The CPU gets the bus back only after the backlog is empty. The block outputs:
- a registered one-hot grant;
- a one-clock refresh command strobe at the start of each refresh occupancy;
- a stall flag for the CPU.

Top module: `rfsh_sched`

## Requirements
- R1: The interval select maps to a refresh period in clocks as follows: 0→47, 1→78, 2→156, 3→312, 4→468, 5→624, 6→936, 7→1248. With the bus otherwise free, the first refresh strobe appears on the (L+1)-th rising edge after reset is released, and later strobes follow every L clocks.
- R2: The select is sampled only when the timer reloads. A change made in the middle of a period takes effect from the period after the current one ends.
- R3: `bus_grant` is zero or one-hot, encoded as bit 0 = CPU, bit 1 = refresh, bit 2 = display. When `disp_req` is high and no refresh occupancy is in its first clock, the display engine is granted on the next edge.
- R4: Each timer expiry while the display engine holds the bus increments the backlog. The timer keeps counting during that time.
- R5: Once `disp_req` drops, the stored refreshes are issued back to back, with one strobe every 2 clocks. The CPU is granted only after the last one completes.
- R6: The backlog is 4 bits wide and saturates at 15. Expiries beyond that are lost.
- R7: Each refresh holds `bus_grant` = refresh for exactly 2 clocks. `ref_cmd` is high only in the first of them. A display request cannot take the bus during the second clock.
- R8: `cpu_stall` is high exactly when `cpu_req` is high and bit 0 of `bus_grant` is low. The CPU is granted only if, on the previous clock, `disp_req` was low and the backlog was empty. With no requester, `bus_grant` is zero.
- R9: Synchronous active-high reset clears the grants, the strobe, the backlog and the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ivl_sel | input | 3 | Refresh period select |
| disp_req | input | 1 | Display DMA bus request |
| cpu_req | input | 1 | CPU bus request |
| bus_grant | output | 3 | One-hot grant: bit0 CPU, bit1 refresh, bit2 display |
| ref_cmd | output | 1 | Auto-refresh command strobe, one clock per refresh |
| cpu_stall | output | 1 | CPU wants the bus and does not have it |

## Verification
A timer expiry lands in the backlog on one edge and shows up as a grant and strobe on the following edge. The first strobe is therefore due L+1 edges after reset, and a strobe released by the display engine is due one edge after `disp_req` is seen low. A grant change always follows its cause by exactly one edge. A refresh occupancy ends two edges after its strobe, so the CPU grant returns on the third.

The bench keeps a cycle counter that restarts with reset. The driver task queues the exact cycle of every expected strobe. The monitor compares each observed strobe against the head of that queue on the falling edge. A strobe that is extra, late or missing is reported, and grant and stall checks are sampled on falling edges at cycles computed from these latencies.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  localparam int GNT_CPU  = 0;
  localparam int GNT_RFSH = 1;
  localparam int GNT_DISP = 2;
  localparam int GNT_W    = 3;

  // Refresh period in system clock cycles for each select code.
  function automatic int unsigned interval_states(input logic [2:0] sel);
    int unsigned n;
    case (sel)
      3'd0: n = 47;
      3'd1: n = 78;
      3'd2: n = 156;
      3'd3: n = 312;
      3'd4: n = 468;
      3'd5: n = 624;
      3'd6: n = 936;
      3'd7: n = 1248;
      default: n = 1248;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int CNT_W = 11,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_new;

  // The select is only looked at when a new period begins.
  assign lim_new = CNT_W'(rfsh_pkg::interval_states(3'(sel)));
  assign tick    = (cnt_q == lim_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= lim_new;
    end else if (tick) begin
      cnt_q <= '0;
      lim_q <= lim_new;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         pending
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt_q != TOP) cnt_q <= cnt_q + W'(1);
        2'b01:   if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count   = cnt_q;
  assign pending = (cnt_q != '0);
endmodule

// File: rtl/rfsh_bus_arbiter.sv
module rfsh_bus_arbiter #(
  parameter int BURST = 2,
  localparam int PH_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     disp_req,
  input  logic                     rfsh_pend,
  input  logic                     cpu_req,
  output logic [rfsh_pkg::GNT_W-1:0] grant,
  output logic                     ref_cmd,
  output logic                     take
);
  import rfsh_pkg::*;

  logic [PH_W-1:0]  left_q, left_d;
  logic [GNT_W-1:0] grant_q, grant_d;
  logic             cmd_q, cmd_d;

  // Decisions happen only when no refresh occupancy is running.
  always_comb begin
    grant_d = '0;
    left_d  = left_q;
    cmd_d   = 1'b0;
    take    = 1'b0;
    if (left_q != '0) begin
      grant_d[GNT_RFSH] = 1'b1;
      left_d            = left_q - PH_W'(1);
    end else if (disp_req) begin
      grant_d[GNT_DISP] = 1'b1;
    end else if (rfsh_pend) begin
      grant_d[GNT_RFSH] = 1'b1;
      take              = 1'b1;
      cmd_d             = 1'b1;
      left_d            = PH_W'(BURST - 1);
    end else if (cpu_req) begin
      grant_d[GNT_CPU] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      grant_q <= '0;
      cmd_q   <= 1'b0;
    end else begin
      left_q  <= left_d;
      grant_q <= grant_d;
      cmd_q   <= cmd_d;
    end
  end

  assign grant   = grant_q;
  assign ref_cmd = cmd_q;
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int CNT_W  = 11,
  parameter int BLOG_W = 4,
  parameter int BURST  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] ivl_sel,
  input  logic       disp_req,
  input  logic       cpu_req,
  output logic [2:0] bus_grant,
  output logic       ref_cmd,
  output logic       cpu_stall
);
  import rfsh_pkg::*;

  logic              tick;
  logic              take;
  logic              pend;
  logic [BLOG_W-1:0] blog_q;

  rfsh_interval_timer #(.CNT_W(CNT_W), .SEL_W(3)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .sel  (ivl_sel),
    .tick (tick)
  );

  rfsh_backlog #(.W(BLOG_W)) u_blog (
    .clk     (clk),
    .rst     (rst),
    .inc     (tick),
    .dec     (take),
    .count   (blog_q),
    .pending (pend)
  );

  rfsh_bus_arbiter #(.BURST(BURST)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .disp_req  (disp_req),
    .rfsh_pend (pend),
    .cpu_req   (cpu_req),
    .grant     (bus_grant),
    .ref_cmd   (ref_cmd),
    .take      (take)
  );

  assign cpu_stall = cpu_req & ~bus_grant[GNT_CPU];
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int BLOG_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              disp_req,
  input logic [2:0]        bus_grant,
  input logic              ref_cmd,
  input logic [BLOG_W-1:0] blog
);
  localparam logic [BLOG_W-1:0] TOP = {BLOG_W{1'b1}};

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_grant));

  // R3
  disp_first_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_req && !ref_cmd) |=> bus_grant[2]);

  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |=> (bus_grant[1] && !ref_cmd));

  // R7
  cmd_owns_chk: assert property (@(posedge clk) disable iff (rst)
    ref_cmd |-> bus_grant[1]);

  // R5
  drain_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (blog < $past(blog)) |-> ref_cmd);

  // R8
  cpu_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bus_grant[0] |-> ($past(!disp_req) && ($past(blog) == '0)));

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (($past(blog) == TOP) && !ref_cmd) |-> (blog == TOP));
endmodule

bind rfsh_sched rfsh_sched_chk #(.BLOG_W(BLOG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .disp_req  (disp_req),
  .bus_grant (bus_grant),
  .ref_cmd   (ref_cmd),
  .blog      (blog_q)
);

// File: tb/sim_rfsh_sched.sv
`timescale 1ns/1ps
module sim_rfsh_sched;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ivl_sel = 3'd0;
  logic       disp_req = 1'b0;
  logic       cpu_req = 1'b0;
  logic [2:0] bus_grant;
  logic       ref_cmd;
  logic       cpu_stall;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  bit finished = 1'b0;

  localparam logic [2:0] G_NONE = 3'b000;
  localparam logic [2:0] G_CPU  = 3'b001;
  localparam logic [2:0] G_RFSH = 3'b010;
  localparam logic [2:0] G_DISP = 3'b100;

  always #10 clk = ~clk;

  rfsh_sched u0 (
    .clk       (clk),
    .rst       (rst),
    .ivl_sel   (ivl_sel),
    .disp_req  (disp_req),
    .cpu_req   (cpu_req),
    .bus_grant (bus_grant),
    .ref_cmd   (ref_cmd),
    .cpu_stall (cpu_stall)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic int period_of(input int s);
    case (s)
      0: return 47;
      1: return 78;
      2: return 156;
      3: return 312;
      4: return 468;
      5: return 624;
      6: return 936;
      default: return 1248;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  // Driver side of the scoreboard: cycle at which a strobe is due.
  task automatic expect_ref(input int c);
    exp_q.push_back(c);
  endtask

  // Monitor: every observed strobe must match the head of the queue.
  always @(negedge clk) begin
    if (!rst && ref_cmd) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1/R5 unexpected strobe", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(e == cyc, "R1/R5 strobe cycle", cyc, e);
      end
    end
  end

  task automatic at_cyc(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] s, input logic d, input logic c);
    @(negedge clk);
    rst = 1'b1;
    ivl_sel = s;
    disp_req = d;
    cpu_req = c;
    exp_q.delete();
    repeat (2) @(negedge clk);
    // R9: state after reset edges
    chk(bus_grant == G_NONE, "R9 grant in reset", int'(bus_grant), 0);
    chk(ref_cmd == 1'b0, "R9 strobe in reset", int'(ref_cmd), 0);
    rst = 1'b0;
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    #(64'd200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 / R9: every select code, first strobe L+1 after reset, then L apart
    for (int s = 0; s < 8; s++) begin
      int L;
      L = period_of(s);
      do_reset(3'(s), 1'b0, 1'b1);
      expect_ref(L + 1);
      expect_ref(2 * L + 1);
      at_cyc(10);
      chk(bus_grant == G_CPU, "R8 cpu granted when idle", int'(bus_grant), int'(G_CPU));
      chk(cpu_stall == 1'b0, "R8 no stall", int'(cpu_stall), 0);
      at_cyc(L + 2);
      chk(bus_grant == G_RFSH, "R7 second refresh clock", int'(bus_grant), int'(G_RFSH));
      chk(cpu_stall == 1'b1, "R8 stall during refresh", int'(cpu_stall), 1);
      at_cyc(L + 3);
      chk(bus_grant == G_CPU, "R7 burst is 2 clocks", int'(bus_grant), int'(G_CPU));
      at_cyc(2 * L + 4);
      drained("R1 strobes outstanding");
    end

    // R2: select change mid-period applies after the current period
    do_reset(3'd2, 1'b0, 1'b1);
    expect_ref(157);
    expect_ref(204);
    expect_ref(251);
    at_cyc(60);
    ivl_sel = 3'd0;
    at_cyc(255);
    drained("R2 strobes outstanding");

    // R4 / R5 / R3: display holds across 4 expiries, then replay
    do_reset(3'd0, 1'b1, 1'b1);
    expect_ref(201);
    expect_ref(203);
    expect_ref(205);
    expect_ref(207);
    expect_ref(236);
    at_cyc(100);
    chk(bus_grant == G_DISP, "R3 display holds bus", int'(bus_grant), int'(G_DISP));
    chk(cpu_stall == 1'b1, "R8 stall while display", int'(cpu_stall), 1);
    at_cyc(200);
    disp_req = 1'b0;
    at_cyc(204);
    chk(bus_grant == G_RFSH, "R5 replay keeps cpu off", int'(bus_grant), int'(G_RFSH));
    chk(cpu_stall == 1'b1, "R5 cpu stalled during replay", int'(cpu_stall), 1);
    at_cyc(208);
    chk(bus_grant == G_RFSH, "R5 last replay burst", int'(bus_grant), int'(G_RFSH));
    at_cyc(209);
    chk(bus_grant == G_CPU, "R5 cpu after backlog empty", int'(bus_grant), int'(G_CPU));
    at_cyc(240);
    drained("R4 timer kept running");

    // R6: 17 expiries during hold, only 15 replayed
    do_reset(3'd0, 1'b1, 1'b1);
    for (int i = 0; i < 15; i++) expect_ref(801 + 2 * i);
    expect_ref(847);
    at_cyc(800);
    disp_req = 1'b0;
    at_cyc(831);
    chk(bus_grant == G_CPU, "R6 backlog capped at 15", int'(bus_grant), int'(G_CPU));
    at_cyc(850);
    drained("R6 strobes outstanding");

    // R7 / R3 / R8: display cannot cut a refresh; idle grant
    do_reset(3'd0, 1'b0, 1'b1);
    expect_ref(48);
    expect_ref(95);
    at_cyc(48);
    disp_req = 1'b1;
    at_cyc(49);
    chk(bus_grant == G_RFSH, "R7 no preemption", int'(bus_grant), int'(G_RFSH));
    at_cyc(50);
    chk(bus_grant == G_DISP, "R3 display after burst", int'(bus_grant), int'(G_DISP));
    at_cyc(60);
    disp_req = 1'b0;
    at_cyc(61);
    chk(bus_grant == G_CPU, "R8 cpu back", int'(bus_grant), int'(G_CPU));
    at_cyc(100);
    cpu_req = 1'b0;
    at_cyc(102);
    chk(bus_grant == G_NONE, "R8 no requester", int'(bus_grant), 0);
    chk(cpu_stall == 1'b0, "R8 no stall without request", int'(cpu_stall), 0);
    drained("R7 strobes outstanding");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule